// File: doc/BRIEF.md
# Shadowing Extended Memory Pointer Controller

This block sits on an 8-bit I/O bus as a non-master extended memory controller. Another controller on the bus owns the pointer pair and answers direct reads of it. This block watches every write to the eight pointer locations and keeps its own copies of both 24-bit pointers in step with that owner. When software then reaches memory indirectly through either pointer, the block serves the access from a local byte array, but only if the pointer falls inside a window set by two static configuration inputs.

Each pointer has four I/O locations. They differ only in how the pointer moves around an indirect access: not at all, lowered first, raised afterwards, or both. The pointers are write-only through their own locations. A separate read-only diagnostic location returns the current value of the second pointer one byte at a time, so a debugger can confirm that the shadow copy tracks the master.

A bus access starts on the rising edge of its strobe. Read data and the output enable appear one clock later and stay valid while the strobe is held. A read strobe must therefore be held for at least two clocks.

Top module: `xmem_shadow`

## Requirements
- R1: Offsets 0xC8..0xCB address pointer A and 0xCC..0xCF address pointer B (offset bit 2 selects the pointer). Offset bits [1:0] pick the variant: 00 plain, 01 decrement, 10 increment, 11 decrement and increment.
- R2: A direct write (`io_ind_i` low) to any location of a pointer stores the data byte into that pointer, least significant byte first. A per-pointer byte counter steps 0,1,2 and returns to 0 after the third byte.
- R3: A direct read of any of the eight pointer locations never asserts `io_oe_o`.
- R4: A pointer is updated by every direct write and every indirect access, whether or not its value lies in the window.
- R5: An indirect write stores `io_wdata_i` into the array at index (effective pointer − base) only on a window hit. On a miss the array is unchanged.
- R6: An indirect read that hits the window asserts `io_oe_o` with the array byte from the clock after the strobe rises. On a miss `io_oe_o` stays low.
- R7: The decrement variants lower the pointer by one before the access, so the access uses pointer−1. The increment variants raise it by one after the access. The combined variant uses pointer−1 and leaves the pointer unchanged.
- R8: Any indirect access through a pointer returns that pointer's byte counter to 0.
- R9: A direct read of offset 0xF0 asserts `io_oe_o` and returns pointer B one byte per read, least significant byte first, using its own counter that wraps after three reads. This read never changes pointer B.
- R10: A pointer hits when base <= pointer < base + min(`win_size_i`, MEM_BYTES).
- R11: `io_oe_o` falls in the same cycle as `io_rd_i`.
- R12: After reset both pointers, both byte counters and the diagnostic counter are zero, and `io_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 8 | I/O offset |
| io_wdata_i | input | 8 | Write data |
| io_rd_i | input | 1 | Read strobe, level |
| io_wr_i | input | 1 | Write strobe, level |
| io_ind_i | input | 1 | High: access goes through the pointer to memory |
| win_base_i | input | 24 | Window base address (static) |
| win_size_i | input | 24 | Window size in bytes (static) |
| io_rdata_o | output | 8 | Read data |
| io_oe_o | output | 1 | Read data drive enable |

## Verification
Several behaviours are checked on every cycle by the assertions. The byte counters never leave their three legal states. Direct pointer reads and window misses never raise the output enable, and it rises only after a read strobe edge. A diagnostic read leaves pointer B untouched, and an increment-only indirect access moves its pointer by exactly one. Other behaviours can only be shown by the bench's scenarios, because they depend on the data that actually lands in memory. These are the window bounds, including the size cap and the lower edge, the absence of aliasing from out-of-window writes, the pre-decrement address arithmetic, and the byte order of pointer loads and diagnostic reads.

// File: rtl/xmem_shadow_pkg.sv
package xmem_shadow_pkg;
  localparam int unsigned PTR_W    = 24;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NBYTES   = PTR_W / BYTE_W;
  localparam int unsigned NPTR     = 2;
  localparam logic [4:0]  PTR_GRP  = 5'b11001;  // 0xC8..0xCF
  localparam logic [7:0]  DIAG_OFF = 8'hF0;

  typedef struct packed {
    logic inc;
    logic dec;
  } ptr_op_t;
endpackage

// File: rtl/xmem_ptr_unit.sv
module xmem_ptr_unit
  import xmem_shadow_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ind_i,
  input  ptr_op_t           op_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [PTR_W-1:0]  eff_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [1:0]       cnt_q;

  assign ptr_o = ptr_q;
  assign eff_o = ptr_q - PTR_W'(op_i.dec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (ind_i) begin
      ptr_q <= eff_o + PTR_W'(op_i.inc);
      cnt_q <= '0;
    end else if (load_i) begin
      ptr_q[{cnt_q, 3'b000} +: BYTE_W] <= byte_i;
      cnt_q <= (cnt_q == 2'(NBYTES - 1)) ? 2'd0 : cnt_q + 2'd1;
    end
  end

  a_r2_cnt_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != 2'd3);
  a_r7_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_i && op_i.inc && !op_i.dec) |=> ptr_o == $past(ptr_o) + 24'd1);
endmodule

// File: rtl/xmem_win_mem.sv
module xmem_win_mem
  import xmem_shadow_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 1024
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [PTR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  base_i,
  input  logic [PTR_W-1:0]  size_i,
  output logic              hit_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned    AW  = $clog2(MEM_BYTES);
  localparam logic [PTR_W-1:0] CAP = PTR_W'(MEM_BYTES);

  logic [BYTE_W-1:0] mem_q [MEM_BYTES];
  logic [PTR_W-1:0]  size_eff, offs;

  assign size_eff = (size_i > CAP) ? CAP : size_i;
  assign offs     = addr_i - base_i;
  assign hit_o    = (addr_i >= base_i) && (offs < size_eff);

  always_ff @(posedge clk_i) begin
    if (we_i && hit_o) mem_q[offs[AW-1:0]] <= wdata_i;
    if (re_i && hit_o) rdata_o <= mem_q[offs[AW-1:0]];
  end
endmodule

// File: rtl/xmem_shadow.sv
module xmem_shadow
  import xmem_shadow_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  io_addr_i,
  input  logic [7:0]  io_wdata_i,
  input  logic        io_rd_i,
  input  logic        io_wr_i,
  input  logic        io_ind_i,
  input  logic [23:0] win_base_i,
  input  logic [23:0] win_size_i,
  output logic [7:0]  io_rdata_o,
  output logic        io_oe_o
);
  logic rd_q, wr_q, rd_rise, wr_rise;
  logic is_ptr, is_diag, ind_acc, diag_rd, hit;
  ptr_op_t op;
  logic [PTR_W-1:0]  ptr_val [NPTR];
  logic [PTR_W-1:0]  eff_val [NPTR];
  logic [PTR_W-1:0]  eff;
  logic [BYTE_W-1:0] mem_rdata, diag_byte_q;
  logic [1:0]        dcnt_q;
  logic              oe_q, src_diag_q;

  assign rd_rise = io_rd_i & ~rd_q;
  assign wr_rise = io_wr_i & ~wr_q;
  assign is_ptr  = io_addr_i[7:3] == PTR_GRP;
  assign is_diag = io_addr_i == DIAG_OFF;
  assign op      = '{inc: io_addr_i[1], dec: io_addr_i[0]};
  assign ind_acc = is_ptr & io_ind_i & (rd_rise | wr_rise);
  assign diag_rd = rd_rise & is_diag & ~io_ind_i;
  assign eff     = eff_val[io_addr_i[2]];

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    logic sel;
    assign sel = io_addr_i[2] == 1'(k);
    xmem_ptr_unit i_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (wr_rise & is_ptr & ~io_ind_i & sel),
      .byte_i (io_wdata_i),
      .ind_i  (ind_acc & sel),
      .op_i   (op),
      .ptr_o  (ptr_val[k]),
      .eff_o  (eff_val[k])
    );
  end

  xmem_win_mem #(.MEM_BYTES(MEM_BYTES)) i_mem (
    .clk_i   (clk_i),
    .we_i    (wr_rise & is_ptr & io_ind_i),
    .re_i    (rd_rise & is_ptr & io_ind_i),
    .addr_i  (eff),
    .wdata_i (io_wdata_i),
    .base_i  (win_base_i),
    .size_i  (win_size_i),
    .hit_o   (hit),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q        <= 1'b0;
      wr_q        <= 1'b0;
      oe_q        <= 1'b0;
      src_diag_q  <= 1'b0;
      dcnt_q      <= '0;
      diag_byte_q <= '0;
    end else begin
      rd_q <= io_rd_i;
      wr_q <= io_wr_i;
      if (!io_rd_i) oe_q <= 1'b0;
      else if (rd_rise) oe_q <= (is_ptr & io_ind_i & hit) | diag_rd;
      if (rd_rise) src_diag_q <= diag_rd;
      if (diag_rd) begin
        diag_byte_q <= ptr_val[1][{dcnt_q, 3'b000} +: BYTE_W];
        dcnt_q      <= (dcnt_q == 2'(NBYTES - 1)) ? 2'd0 : dcnt_q + 2'd1;
      end
    end
  end

  assign io_rdata_o = src_diag_q ? diag_byte_q : mem_rdata;
  assign io_oe_o    = io_rd_i & oe_q;

  a_r3_direct_read_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && is_ptr && !io_ind_i) |=> !io_oe_o);
  a_r6_miss_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && is_ptr && io_ind_i && !hit) |=> !io_oe_o);
  a_r11_oe_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_oe_o) |-> $past(rd_rise));
  a_r9_diag_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diag_rd && !wr_rise) |=> $stable(ptr_val[1]));
endmodule

// File: tb/test_xmem_shadow.sv
module test_xmem_shadow;
  localparam int CLK_PERIOD = 10;
  localparam int MEMB = 64;

  logic clk = 0, rst_ni = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic rd = 0, wr = 0, ind = 0;
  logic [23:0] base = 24'h100, size = 24'h40;
  logic [7:0] rdata;
  logic oe;
  int n_tests = 0, n_fail = 0;
  logic [23:0] m_p2;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_shadow #(.MEM_BYTES(MEMB)) i_xmem_shadow (
    .clk_i(clk), .rst_ni(rst_ni), .io_addr_i(addr), .io_wdata_i(wdata),
    .io_rd_i(rd), .io_wr_i(wr), .io_ind_i(ind), .win_base_i(base),
    .win_size_i(size), .io_rdata_o(rdata), .io_oe_o(oe));

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic in_win(logic [23:0] p);
    logic [23:0] lim;
    lim = (size > 24'(MEMB)) ? 24'(MEMB) : size;
    return (p >= base) && ((p - base) < lim);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [7:0] d, logic i);
    @(negedge clk); addr = a; wdata = d; ind = i; wr = 1;
    @(negedge clk); wr = 0;
    @(negedge clk);
  endtask

  task automatic bus_rd(logic [7:0] a, logic i, output logic [7:0] d, output logic e, input string req);
    @(negedge clk); addr = a; ind = i; rd = 1;
    @(negedge clk); d = rdata; e = oe;
    rd = 0; #1;
    chk({req, " R11 oe drop"}, 32'(oe), 0);
    @(negedge clk);
  endtask

  task automatic load(logic [7:0] a, logic [23:0] v);
    for (int b = 0; b < 3; b++) bus_wr(a, v[b*8 +: 8], 0);
  endtask

  task automatic diag(logic [23:0] exp, string req);
    logic [7:0] d; logic e; logic [23:0] v;
    for (int b = 0; b < 3; b++) begin
      bus_rd(8'hF0, 0, d, e, req);
      chk({req, " diag oe"}, 32'(e), 1);
      v[b*8 +: 8] = d;
    end
    chk({req, " diag value"}, 32'(v), 32'(exp));
  endtask

  // indirect read via pointer B at location a, tracking model m_p2
  task automatic rd_b(logic [7:0] a, logic [7:0] expd, string req);
    logic [7:0] d; logic e; logic [23:0] effp; logic h;
    effp = m_p2 - 24'(a[0]);
    h = in_win(effp);
    m_p2 = effp + 24'(a[1]);
    bus_rd(a, 1, d, e, req);
    chk({req, " hit"}, 32'(e), 32'(h));
    if (h) chk({req, " data"}, 32'(d), 32'(expd));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d; logic e;
    #(CLK_PERIOD * 2 + 1);
    chk("R12 oe reset", 32'(oe), 0);
    rst_ni = 1;
    diag(24'h0, "R12");

    // R2 load B, R9 read twice unchanged
    load(8'hCC, 24'hA5B6C7);
    diag(24'hA5B6C7, "R2");
    diag(24'hA5B6C7, "R9");
    load(8'hCD, 24'h123456);  // any variant loads
    diag(24'h123456, "R1");

    // R3 direct reads of all pointer locations
    for (int k = 0; k < 8; k++) begin
      bus_rd(8'hC8 + 8'(k), 0, d, e, "R3");
      chk("R3 direct read oe", 32'(e), 0);
    end

    // R1/R5/R7 fill window through pointer A with increment
    load(8'hC8, 24'h000100);
    diag(24'h123456, "R1 A isolated from B");
    for (int i = 0; i < MEMB; i++) bus_wr(8'hCA, pat(i), 1);
    bus_wr(8'hCA, 8'hEE, 1);  // miss at 0x140

    m_p2 = 24'h100;
    load(8'hCC, m_p2);
    for (int i = 0; i < MEMB; i++) rd_b(8'hCE, pat(i), "R6");
    rd_b(8'hCE, 8'h00, "R10 upper");
    diag(24'h000141, "R4");
    rd_b(8'hCD, 8'h00, "R7 dec miss");
    rd_b(8'hCD, pat(63), "R7 dec");
    rd_b(8'hCF, pat(62), "R7 both");
    rd_b(8'hCF, pat(62), "R7 both again");
    diag(24'h00013F, "R7");

    m_p2 = 24'h0000FF; load(8'hCC, m_p2);
    rd_b(8'hCC, 8'h00, "R10 lower");
    m_p2 = 24'h000100; load(8'hCC, m_p2);
    rd_b(8'hCC, pat(0), "R5 no alias");

    size = 24'h1000;
    m_p2 = 24'h00013F; load(8'hCC, m_p2);
    rd_b(8'hCE, pat(63), "R10 cap");
    rd_b(8'hCE, 8'h00, "R10 cap edge");

    base = 24'h0; size = 24'h10;
    m_p2 = 24'h0; load(8'hCC, m_p2);
    for (int i = 0; i < 20; i++) rd_b(8'hCE, pat(i), "R10 sweep");

    // R8 partial load then indirect access resets counter
    base = 24'h100; size = 24'h40;
    bus_wr(8'hCC, 8'h55, 0);
    m_p2 = {m_p2[23:8], 8'h55};
    rd_b(8'hCC, 8'h00, "R8 access");
    m_p2 = 24'h000102; load(8'hCC, m_p2);
    diag(24'h000102, "R8");
    rd_b(8'hCC, pat(2), "R8 data");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule